// File: doc/BRIEF.md
# Minimal 32-bit Register-Machine Core

This block is a small single-issue processor core that runs one instruction at a time over three clock phases. It presents the program counter as a word address to a synchronous instruction memory and captures the returned word into an instruction register. It then executes the word against a sixteen-entry register file and updates the program counter. Every instruction is exactly one 32-bit word. The top byte selects the operation. Register selectors are four bits wide. Control transfers carry their target as a direct 16-bit word address in the low half of the word.

The core provides register-to-register arithmetic, bitwise logic and shifts. It also provides an unconditional jump, four conditional jumps that compare two registers, and a one-level call/return pair. The return address of that pair is kept in a hidden register, so ordinary arithmetic cannot reach it. There are no data loads or stores. A combinational debug port reads any register, so an environment can observe the results of a program.

Top module: `cpu_core`

## Requirements
- R1: While reset is asserted, and right after it is released, the program counter (`mem_addr`) reads 0 and every register reads 0 through the debug port; the hidden return register is also cleared to 0.
- R2: Instruction word fields: opcode in [31:24]; for ALU operations the destination is [23:20], the first source rX is [19:16] and the second source rY is [15:12]. Bits [11:0] have no effect on an ALU operation.
- R3: ADD (0x01) writes rX+rY and SUB (0x02) writes rX-rY, both modulo 2^32.
- R4: NOT (0x03) writes the bitwise complement of rX (rY is not used); AND (0x04), OR (0x05) and XOR (0x06) write the bitwise result of rX and rY.
- R5: SHL (0x07) writes rX shifted left and SHR (0x08) writes rX shifted right with zero fill. In both cases the distance is rY[4:0], so a distance of 33 shifts by 1.
- R6: Each instruction takes exactly three clock cycles. `mem_addr` equals the program counter, stays unchanged during the first two cycles after reset or after the previous instruction, and becomes PC+1 at the end of the third cycle for any instruction that does not transfer control.
- R7: NOP (0x00) and every undefined opcode (any value other than those listed in R3, R4, R5, R8, R9 and R10) leave all registers unchanged and only advance the program counter by 1.
- R8: JMP (0x10) loads the program counter with bits [15:0] and writes no register.
- R9: JEQ (0x11), JNE (0x12), JLT (0x13) and JLE (0x14) compare rA=[23:20] with rB=[19:16] as signed two's-complement values. When the condition holds, the program counter loads [15:0]; otherwise it advances by 1. No register is written in either case.
- R10: CALL (0x18) stores PC+1 in the hidden return register and jumps to [15:0]. RET (0x19) jumps to the stored address. Only one return address is held, and RET right after reset jumps to 0.
- R11: `dbg_data` always shows the current contents of the register selected by `dbg_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Instruction word address (the program counter) |
| mem_rdata | input | 32 | Instruction word returned by the memory one cycle after `mem_addr` |
| dbg_sel | input | 4 | Register selector for the debug read port |
| dbg_data | output | 32 | Contents of the selected register |

## Verification
The bench builds the core with its default parameters: 32-bit words, a 16-bit program counter and sixteen registers. All sixteen registers are therefore reachable through the debug port, and every shift distance up to 31 and its modulo-32 wrap can be exercised. The bench's behavioural memory holds 64 words, so jump and call targets stay in a small window. A bench-side instruction model runs the same programs, and each register and the program counter are compared against it. Hand-worked values check wraparound, logical right shift and signed comparison of -1 against 1.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

  localparam int OPC_W = 8;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP  = 8'h00,
    OP_ADD  = 8'h01,
    OP_SUB  = 8'h02,
    OP_NOT  = 8'h03,
    OP_AND  = 8'h04,
    OP_OR   = 8'h05,
    OP_XOR  = 8'h06,
    OP_SHL  = 8'h07,
    OP_SHR  = 8'h08,
    OP_JMP  = 8'h10,
    OP_JEQ  = 8'h11,
    OP_JNE  = 8'h12,
    OP_JLT  = 8'h13,
    OP_JLE  = 8'h14,
    OP_CALL = 8'h18,
    OP_RET  = 8'h19
  } opcode_e;

  // three phases per instruction: address out, word captured, execute
  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_LATCH = 2'd1,
    ST_EXEC  = 2'd2
  } phase_e;

endpackage

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int W = 32,
  parameter int N = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] wsel,
  input  logic [W-1:0]         wdata,
  input  logic [$clog2(N)-1:0] sel_p,
  input  logic [$clog2(N)-1:0] sel_x,
  input  logic [$clog2(N)-1:0] sel_y,
  input  logic [$clog2(N)-1:0] sel_d,
  output logic [W-1:0]         val_p,
  output logic [W-1:0]         val_x,
  output logic [W-1:0]         val_y,
  output logic [W-1:0]         val_d
);

  logic [W-1:0] regs [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wsel] <= wdata;
    end
  end

  assign val_p = regs[sel_p];
  assign val_x = regs[sel_x];
  assign val_y = regs[sel_y];
  assign val_d = regs[sel_d];

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OPC_W-1:0] opc,
  input  logic [W-1:0]     x,
  input  logic [W-1:0]     y,
  output logic [W-1:0]     res,
  output logic             writes
);

  localparam int SH_W = $clog2(W);

  function automatic logic [W-1:0] calc(logic [OPC_W-1:0] o, logic [W-1:0] a, logic [W-1:0] b);
    case (opcode_e'(o))
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_NOT:  return ~a;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      OP_SHL:  return a << b[SH_W-1:0];
      OP_SHR:  return a >> b[SH_W-1:0];
      default: return '0;
    endcase
  endfunction

  function automatic logic is_alu(logic [OPC_W-1:0] o);
    case (opcode_e'(o))
      OP_ADD, OP_SUB, OP_NOT, OP_AND, OP_OR, OP_XOR, OP_SHL, OP_SHR: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  assign res    = calc(opc, x, y);
  assign writes = is_alu(opc);

endmodule

// File: rtl/cpu_branch.sv
module cpu_branch
  import cpu_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 16
) (
  input  logic [OPC_W-1:0] opc,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [AW-1:0]    target,
  input  logic [AW-1:0]    pc,
  input  logic [AW-1:0]    ret_addr,
  output logic             taken,
  output logic [AW-1:0]    next_pc,
  output logic [AW-1:0]    link,
  output logic             save_ret
);

  function automatic logic decide(logic [OPC_W-1:0] o, logic [W-1:0] l, logic [W-1:0] r);
    logic eq;
    logic lt;
    eq = (l == r);
    lt = ($signed(l) < $signed(r));
    case (opcode_e'(o))
      OP_JMP, OP_CALL, OP_RET: return 1'b1;
      OP_JEQ:  return eq;
      OP_JNE:  return !eq;
      OP_JLT:  return lt;
      OP_JLE:  return lt || eq;
      default: return 1'b0;
    endcase
  endfunction

  always_comb begin
    link     = pc + AW'(1);
    taken    = decide(opc, a, b);
    save_ret = (opc == OP_CALL);
    if (!taken)             next_pc = link;
    else if (opc == OP_RET) next_pc = ret_addr;
    else                    next_pc = target;
  end

endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int NREG   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic [DATA_W-1:0]       mem_rdata,
  input  logic [$clog2(NREG)-1:0] dbg_sel,
  output logic [DATA_W-1:0]       dbg_data
);

  localparam int RSEL_W  = $clog2(NREG);
  localparam int OPC_LSB = DATA_W - OPC_W;
  localparam int A_LSB   = OPC_LSB - RSEL_W;
  localparam int B_LSB   = A_LSB - RSEL_W;
  localparam int C_LSB   = B_LSB - RSEL_W;

  phase_e              phase;
  logic [ADDR_W-1:0]   pc;
  logic [ADDR_W-1:0]   ret_q;
  logic [DATA_W-1:0]   ir;

  logic [OPC_W-1:0]    opc;
  logic [RSEL_W-1:0]   fa, fb, fc;
  logic [ADDR_W-1:0]   target;
  logic [DATA_W-1:0]   val_a, val_x, val_y;
  logic [DATA_W-1:0]   alu_res;
  logic                alu_wr;

  // named events used by the bound checker
  logic                ex_fire;
  logic                ex_taken;
  logic [ADDR_W-1:0]   ex_target;
  logic [ADDR_W-1:0]   link;
  logic                save_ret;
  logic                wr_en;

  assign opc    = ir[DATA_W-1 -: OPC_W];
  assign fa     = ir[A_LSB +: RSEL_W];
  assign fb     = ir[B_LSB +: RSEL_W];
  assign fc     = ir[C_LSB +: RSEL_W];
  assign target = ir[ADDR_W-1:0];

  assign ex_fire  = (phase == ST_EXEC);
  assign wr_en    = ex_fire && alu_wr;
  assign mem_addr = pc;

  cpu_regfile #(.W(DATA_W), .N(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .wsel  (fa),
    .wdata (alu_res),
    .sel_p (fa),
    .sel_x (fb),
    .sel_y (fc),
    .sel_d (dbg_sel),
    .val_p (val_a),
    .val_x (val_x),
    .val_y (val_y),
    .val_d (dbg_data)
  );

  cpu_alu #(.W(DATA_W)) u_alu (
    .opc    (opc),
    .x      (val_x),
    .y      (val_y),
    .res    (alu_res),
    .writes (alu_wr)
  );

  // branch operands: rA in the destination slot, rB in the first-source slot
  cpu_branch #(.W(DATA_W), .AW(ADDR_W)) u_br (
    .opc      (opc),
    .a        (val_a),
    .b        (val_x),
    .target   (target),
    .pc       (pc),
    .ret_addr (ret_q),
    .taken    (ex_taken),
    .next_pc  (ex_target),
    .link     (link),
    .save_ret (save_ret)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= ST_FETCH;
      pc    <= '0;
      ret_q <= '0;
      ir    <= '0;
    end else begin
      case (phase)
        ST_FETCH: phase <= ST_LATCH;
        ST_LATCH: begin
          ir    <= mem_rdata;
          phase <= ST_EXEC;
        end
        default: begin
          pc    <= ex_target;
          if (save_ret) ret_q <= link;
          phase <= ST_FETCH;
        end
      endcase
    end
  end

endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk
  import cpu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        phase,
  input logic [ADDR_W-1:0] pc,
  input logic [OPC_W-1:0]  opc,
  input logic              ex_fire,
  input logic              ex_taken,
  input logic [ADDR_W-1:0] ex_target,
  input logic              wr_en
);

  // R1: first active cycle after reset starts from address 0
  p_reset_pc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pc == '0);

  // R6: phase order fetch -> latch -> execute -> fetch
  p_fetch_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phase == ST_FETCH |=> phase == ST_LATCH);
  p_latch_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phase == ST_LATCH |=> phase == ST_EXEC);
  p_exec_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ex_fire |=> phase == ST_FETCH);

  // R6: program counter only moves at the end of the execute phase
  p_pc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_fire |=> $stable(pc));

  // R6: sequential step after a non-transfer
  p_pc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ex_fire && !ex_taken |=> pc == ADDR_W'($past(pc) + 1'b1));

  // R8: transfers land on the computed destination
  p_pc_jump_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ex_fire && ex_taken |=> pc == $past(ex_target));

  // R7: NOP and undefined opcodes write nothing
  p_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ex_fire && (opc == 8'h00 || opc > 8'h19 || (opc > 8'h08 && opc < 8'h10)) |-> !wr_en);

  // R9: a control transfer never writes a register
  p_branch_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ex_fire && ex_taken |-> !wr_en);

endmodule

bind cpu_core cpu_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .phase     (phase),
  .pc        (pc),
  .opc       (opc),
  .ex_fire   (ex_fire),
  .ex_taken  (ex_taken),
  .ex_target (ex_target),
  .wr_en     (wr_en)
);

// File: tb/test_cpu_core.sv
`timescale 1ns/1ps
module test_cpu_core;

  localparam int DW = 32;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic [3:0]    dbg_sel = '0;
  logic [DW-1:0] dbg_data;

  always #10 clk = ~clk;

  logic [DW-1:0] mem [0:63];
  always_ff @(posedge clk) mem_rdata <= mem[mem_addr[5:0]];

  cpu_core i_cpu_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .dbg_sel   (dbg_sel),
    .dbg_data  (dbg_data)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // bench-side instruction model
  logic [DW-1:0] m_rf [16];
  logic [AW-1:0] m_pc;
  logic [AW-1:0] m_ret;

  function automatic logic [31:0] alu_w(input logic [7:0] op, input int d, input int x, input int y, input logic [11:0] junk);
    return {op, d[3:0], x[3:0], y[3:0], junk};
  endfunction

  function automatic logic [31:0] br_w(input logic [7:0] op, input int a, input int b, input int tgt);
    return {op, a[3:0], b[3:0], tgt[15:0]};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic m_step();
    logic [31:0] w, a, b;
    logic [7:0]  op;
    logic [AW-1:0] nxt;
    w   = mem[m_pc[5:0]];
    op  = w[31:24];
    a   = m_rf[w[23:20]];
    b   = m_rf[w[19:16]];
    nxt = m_pc + 16'd1;
    if (op == 8'h01) m_rf[w[23:20]] = m_rf[w[19:16]] + m_rf[w[15:12]];
    if (op == 8'h02) m_rf[w[23:20]] = m_rf[w[19:16]] - m_rf[w[15:12]];
    if (op == 8'h03) m_rf[w[23:20]] = ~m_rf[w[19:16]];
    if (op == 8'h04) m_rf[w[23:20]] = m_rf[w[19:16]] & m_rf[w[15:12]];
    if (op == 8'h05) m_rf[w[23:20]] = m_rf[w[19:16]] | m_rf[w[15:12]];
    if (op == 8'h06) m_rf[w[23:20]] = m_rf[w[19:16]] ^ m_rf[w[15:12]];
    if (op == 8'h07) m_rf[w[23:20]] = m_rf[w[19:16]] << m_rf[w[15:12]][4:0];
    if (op == 8'h08) m_rf[w[23:20]] = m_rf[w[19:16]] >> m_rf[w[15:12]][4:0];
    if (op == 8'h10) nxt = w[15:0];
    if (op == 8'h11 && a == b) nxt = w[15:0];
    if (op == 8'h12 && a != b) nxt = w[15:0];
    if (op == 8'h13 && $signed(a) < $signed(b)) nxt = w[15:0];
    if (op == 8'h14 && $signed(a) <= $signed(b)) nxt = w[15:0];
    if (op == 8'h18) begin m_ret = nxt; nxt = w[15:0]; end
    if (op == 8'h19) nxt = m_ret;
    m_pc = nxt;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
  endtask

  // r1 = -1, r2 = 1, r3 = 2, r4 = 3
  task automatic prologue();
    mem[0] = alu_w(8'h03, 1, 0, 0, 12'h000);
    mem[1] = alu_w(8'h02, 2, 0, 1, 12'h000);
    mem[2] = alu_w(8'h01, 3, 2, 2, 12'h000);
    mem[3] = alu_w(8'h01, 4, 3, 2, 12'h000);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 16; i++) m_rf[i] = '0;
    m_pc  = '0;
    m_ret = '0;
    rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (3 * n) @(negedge clk);
    for (int i = 0; i < n; i++) m_step();
  endtask

  task automatic rd_reg(input int i, output logic [31:0] v);
    dbg_sel = i[3:0];
    #1;
    v = dbg_data;
  endtask

  // R11: every register through the debug port, plus the program counter
  task automatic cmp_all(input string req);
    logic [31:0] v;
    for (int i = 0; i < 16; i++) begin
      rd_reg(i, v);
      chk(req, $sformatf("R11 reg %0d", i), v, m_rf[i]);
    end
    chk(req, "pc", {16'h0, mem_addr}, {16'h0, m_pc});
  endtask

  task automatic t_arith();
    logic [31:0] v;
    clear_mem();
    prologue();
    mem[4] = alu_w(8'h01, 5, 1, 2, 12'hABC);   // R2 junk low bits
    mem[5] = alu_w(8'h02, 6, 0, 3, 12'hFFF);
    mem[6] = alu_w(8'h02, 7, 4, 3, 12'h000);
    mem[7] = alu_w(8'h01, 8, 1, 1, 12'h5A5);
    do_reset();
    run(8);
    rd_reg(5, v); chk("R3", "add wraps to zero", v, 32'h0);
    rd_reg(6, v); chk("R3", "0-2", v, 32'hFFFF_FFFE);
    rd_reg(7, v); chk("R3", "3-2", v, 32'h1);
    rd_reg(8, v); chk("R2", "junk bits ignored", v, 32'hFFFF_FFFE);
    cmp_all("R3");
  endtask

  task automatic t_reset();
    logic [31:0] v;
    clear_mem();
    prologue();
    do_reset();
    run(4);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < 16; i++) begin
      rd_reg(i, v);
      chk("R1", $sformatf("reg %0d in reset", i), v, 32'h0);
    end
    chk("R1", "pc in reset", {16'h0, mem_addr}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6", "pc held two cycles", {16'h0, mem_addr}, 32'h0);
    @(negedge clk);
    chk("R6", "pc after third cycle", {16'h0, mem_addr}, 32'h1);
    rd_reg(1, v);
    chk("R6", "first instruction written", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_logic();
    logic [31:0] v;
    clear_mem();
    prologue();
    mem[4] = alu_w(8'h03, 5, 3, 9, 12'h000);
    mem[5] = alu_w(8'h04, 6, 5, 4, 12'h000);
    mem[6] = alu_w(8'h05, 7, 3, 2, 12'h000);
    mem[7] = alu_w(8'h06, 8, 1, 4, 12'h000);
    do_reset();
    run(8);
    rd_reg(5, v); chk("R4", "not", v, 32'hFFFF_FFFD);
    rd_reg(6, v); chk("R4", "and", v, 32'h1);
    rd_reg(7, v); chk("R4", "or", v, 32'h3);
    rd_reg(8, v); chk("R4", "xor", v, 32'hFFFF_FFFC);
    cmp_all("R4");
  endtask

  task automatic t_shift();
    logic [31:0] v;
    clear_mem();
    prologue();
    mem[4]  = alu_w(8'h01, 9, 4, 3, 12'h000);   // 5
    mem[5]  = alu_w(8'h07, 7, 2, 9, 12'h000);   // 32
    mem[6]  = alu_w(8'h01, 7, 7, 2, 12'h000);   // 33
    mem[7]  = alu_w(8'h07, 8, 4, 7, 12'h000);   // 3 << 1
    mem[8]  = alu_w(8'h01, 11, 3, 3, 12'h000);  // 4
    mem[9]  = alu_w(8'h08, 10, 1, 11, 12'h000); // logical
    mem[10] = alu_w(8'h07, 5, 2, 4, 12'h000);   // 8
    do_reset();
    run(11);
    rd_reg(8, v);  chk("R5", "shift by 33 acts as 1", v, 32'h6);
    rd_reg(10, v); chk("R5", "right shift zero fill", v, 32'h0FFF_FFFF);
    rd_reg(5, v);  chk("R5", "left shift", v, 32'h8);
    cmp_all("R5");
  endtask

  task automatic t_nop();
    logic [31:0] v;
    clear_mem();
    prologue();
    mem[4] = 32'h00FF_FFFF;
    mem[5] = 32'h0912_3000;
    mem[6] = 32'hEE34_5000;
    mem[7] = 32'h0F10_0000;
    do_reset();
    run(8);
    rd_reg(1, v); chk("R7", "r1 untouched", v, 32'hFFFF_FFFF);
    rd_reg(3, v); chk("R7", "r3 untouched", v, 32'h2);
    chk("R7", "pc advanced", {16'h0, mem_addr}, 32'h8);
    cmp_all("R7");
  endtask

  task automatic t_jump();
    logic [31:0] v;
    clear_mem();
    prologue();
    mem[4] = br_w(8'h10, 0, 0, 7);
    mem[5] = alu_w(8'h01, 5, 2, 2, 12'h000);
    mem[6] = alu_w(8'h01, 6, 2, 2, 12'h000);
    mem[7] = alu_w(8'h01, 7, 3, 3, 12'h000);
    mem[8] = br_w(8'h10, 0, 0, 8);
    do_reset();
    run(6);
    rd_reg(5, v); chk("R8", "skipped r5", v, 32'h0);
    rd_reg(6, v); chk("R8", "skipped r6", v, 32'h0);
    rd_reg(7, v); chk("R8", "target executed", v, 32'h4);
    run(2);
    chk("R8", "self jump holds pc", {16'h0, mem_addr}, 32'h8);
    cmp_all("R8");
  endtask

  task automatic t_branch();
    logic [31:0] v;
    clear_mem();
    prologue();
    mem[4]  = br_w(8'h11, 2, 2, 6);
    mem[5]  = alu_w(8'h01, 5, 2, 2, 12'h000);
    mem[6]  = br_w(8'h12, 2, 2, 20);
    mem[7]  = br_w(8'h13, 1, 2, 9);
    mem[8]  = alu_w(8'h01, 6, 2, 2, 12'h000);
    mem[9]  = br_w(8'h13, 2, 1, 20);
    mem[10] = br_w(8'h14, 3, 3, 12);
    mem[11] = alu_w(8'h01, 7, 2, 2, 12'h000);
    mem[12] = br_w(8'h14, 3, 2, 20);
    mem[13] = br_w(8'h12, 1, 2, 15);
    mem[14] = alu_w(8'h01, 8, 2, 2, 12'h000);
    mem[15] = br_w(8'h11, 1, 2, 20);
    mem[16] = alu_w(8'h01, 9, 2, 2, 12'h000);
    mem[17] = br_w(8'h10, 0, 0, 17);
    mem[20] = br_w(8'h10, 0, 0, 20);
    do_reset();
    run(14);
    rd_reg(5, v); chk("R9", "jeq taken", v, 32'h0);
    rd_reg(6, v); chk("R9", "jlt signed -1<1 taken", v, 32'h0);
    rd_reg(7, v); chk("R9", "jle equal taken", v, 32'h0);
    rd_reg(8, v); chk("R9", "jne taken", v, 32'h0);
    rd_reg(9, v); chk("R9", "fallthrough path", v, 32'h2);
    chk("R9", "final pc", {16'h0, mem_addr}, 32'd17);
    cmp_all("R9");
  endtask

  task automatic t_call();
    logic [31:0] v;
    clear_mem();
    mem[0] = br_w(8'h19, 0, 0, 0);  // RET straight after reset
    do_reset();
    run(2);
    chk("R10", "ret after reset goes to 0", {16'h0, mem_addr}, 32'h0);
    clear_mem();
    prologue();
    mem[4]  = br_w(8'h18, 0, 0, 10);
    mem[5]  = alu_w(8'h01, 5, 3, 4, 12'h000);
    mem[6]  = br_w(8'h10, 0, 0, 6);
    mem[10] = alu_w(8'h01, 6, 4, 4, 12'h000);
    mem[11] = br_w(8'h19, 0, 0, 0);
    do_reset();
    run(5);
    chk("R10", "call target", {16'h0, mem_addr}, 32'd10);
    run(2);
    chk("R10", "return address", {16'h0, mem_addr}, 32'd5);
    rd_reg(6, v); chk("R10", "callee ran", v, 32'h6);
    run(2);
    rd_reg(5, v); chk("R10", "after return", v, 32'h5);
    cmp_all("R10");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_rf[i] = '0;
    m_pc  = '0;
    m_ret = '0;
    clear_mem();
    t_arith();
    t_reset();
    t_logic();
    t_shift();
    t_nop();
    t_jump();
    t_branch();
    t_call();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule